// File: doc/BRIEF.md
# Duplicate Tag Snoop Controller

This controller holds a second copy of the cache tags for two processors, so that coherence lookups never touch the processors' own caches. A coherent request names the requesting processor, a physical address and whether it reads or writes. The controller then reads the duplicate entry of each processor from one shared tag SRAM. It reports per-processor hit and state and says whether the other processor must supply the data. Finally it writes both entries back with their new coherence states under a write-invalidate policy.

Each entry is 15 bits: a 13-bit address tag and a 2-bit state with encoding 00 Invalid, 01 Shared, 10 Owned and 11 Exclusive/Modified (Exclusive and Modified share one code). The SRAM word is 18 bits. The top 3 bits are written as zero and are not used on reads. The SRAM address is the cache index followed by one processor-select bit in the least significant position. The duplicate tags model a direct-mapped cache of 64-byte blocks, so address bits [5:0] are the block offset, the next IDX_W bits are the index and the 13 bits above them are the tag.

The controller is a six-state machine:
- IDLE: ready. It moves to RD0 when a request is accepted.
- RD0: reads the processor 0 entry. It always moves to RD1.
- RD1: reads the processor 1 entry and captures the processor 0 data. It always moves to CAP.
- CAP: captures the processor 1 data. It always moves to WR0.
- WR0: writes processor 0 and presents the response. It always moves to WR1.
- WR1: writes processor 1. It always returns to IDLE.

The SRAM is synchronous, with one cycle of read latency.

Top module: `dtag_snoop_ctrl`

## Requirements
- R1: After reset, and whenever the controller is idle, req_ready is 1, sram_en is 0 and rsp_valid is 0.
- R2: In the cycle after a request is accepted, the SRAM is read at {index,0}. In the next cycle it is read at {index,1}. Only one entry is accessed per cycle.
- R3: rsp_valid is high for exactly one cycle, the fourth cycle after the accepting clock edge. rsp_hit[p] is 1 when processor p's entry has a non-Invalid state and a matching tag. rsp_state0 and rsp_state1 give that processor's state when it hits and 00 when it misses.
- R4: On a read, if the other processor hits in Exclusive/Modified, its entry becomes Owned with the same tag. If it hits in Shared or Owned, its entry keeps its state.
- R5: On a read, the requester's entry becomes {request tag, Shared} when the other processor hits. Otherwise it becomes {request tag, Exclusive/Modified}.
- R6: On a write, the other processor's entry becomes Invalid with its tag kept when it hits. The requester's entry becomes {request tag, Exclusive/Modified}.
- R7: A tag mismatch or an Invalid state counts as a miss. The other processor's entry is then written back with its tag and state unchanged.
- R8: Once a request is accepted, req_ready stays 0 through both update writes, for 5 cycles, and returns to 1 in the sixth cycle.
- R9: Every SRAM write has bits [17:15] equal to 0. Whatever those bits hold in the SRAM has no effect on the hits, states or updates.
- R10: rsp_supply is 1 when the other processor hits in Owned or Exclusive/Modified. rsp_supplier then names that processor.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared with the tag SRAM |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller can accept a request |
| req_pid | input | 1 | Requesting processor |
| req_addr | input | PA_W (23) | Physical address of the block |
| req_write | input | 1 | 1 for a coherent write, 0 for a read |
| rsp_valid | output | 1 | Snoop result is valid this cycle |
| rsp_hit | output | 2 | Hit per processor (bit p is processor p) |
| rsp_state0 | output | 2 | Processor 0 state before the update |
| rsp_state1 | output | 2 | Processor 1 state before the update |
| rsp_supply | output | 1 | Other processor supplies the block |
| rsp_supplier | output | 1 | Processor that supplies the block |
| sram_en | output | 1 | SRAM access enable |
| sram_we | output | 1 | SRAM write enable |
| sram_addr | output | IDX_W+1 (5) | SRAM address {index, processor} |
| sram_wdata | output | 18 | SRAM write data |
| sram_rdata | input | 18 | SRAM read data, one cycle after the read |

## Verification
Two pairs of actions share a cycle. In WR0 the response is presented while the processor 0 entry is written. In RD1 the processor 1 read is issued while the processor 0 data is captured. The bench sweeps every pair of starting states, tag match and mismatch for both processors, both requesters and both request kinds. It preloads the SRAM with junk in the upper bits. In each cycle it checks the response and the SRAM address, and it judges the written words by reading its SRAM model after WR1.

// File: rtl/dtag_pkg.sv
package dtag_pkg;
    localparam int OFF_W = 6;

    typedef enum logic [1:0] {
        ST_INV = 2'b00,
        ST_SHD = 2'b01,
        ST_OWN = 2'b10,
        ST_EXM = 2'b11
    } mosi_e;

    typedef enum logic [2:0] {
        S_IDLE,
        S_RD0,
        S_RD1,
        S_CAP,
        S_WR0,
        S_WR1
    } fsm_e;
endpackage

// File: rtl/dtag_fsm.sv
module dtag_fsm
    import dtag_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic req_valid,
    output logic req_ready,
    output logic accept,
    output logic rd_en,
    output logic rd_sel,
    output logic cap0,
    output logic cap1,
    output logic wr_en,
    output logic wr_sel,
    output logic rsp_valid
);
    fsm_e state;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= S_IDLE;
        end else begin
            unique case (state)
                S_IDLE:  if (req_valid) state <= S_RD0;
                S_RD0:   state <= S_RD1;
                S_RD1:   state <= S_CAP;
                S_CAP:   state <= S_WR0;
                S_WR0:   state <= S_WR1;
                S_WR1:   state <= S_IDLE;
                default: state <= S_IDLE;
            endcase
        end
    end

    always_comb begin
        req_ready = 1'b0;
        rd_en     = 1'b0;
        rd_sel    = 1'b0;
        cap0      = 1'b0;
        cap1      = 1'b0;
        wr_en     = 1'b0;
        wr_sel    = 1'b0;
        rsp_valid = 1'b0;
        unique case (state)
            S_IDLE: req_ready = 1'b1;
            S_RD0:  rd_en = 1'b1;
            S_RD1: begin
                rd_en  = 1'b1;
                rd_sel = 1'b1;
                cap0   = 1'b1;
            end
            S_CAP:  cap1 = 1'b1;
            S_WR0: begin
                wr_en     = 1'b1;
                rsp_valid = 1'b1;
            end
            S_WR1: begin
                wr_en  = 1'b1;
                wr_sel = 1'b1;
            end
            default: ;
        endcase
    end

    assign accept = req_valid && req_ready;

    // R8: an accepted request makes the controller busy on the next cycle
    p_busy_after_accept_r8: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> !req_ready);
endmodule

// File: rtl/dtag_merge.sv
module dtag_merge
    import dtag_pkg::*;
#(
    parameter int TAG_W = 13,
    parameter int ENT_W = TAG_W + 2
) (
    input  logic                       req_pid,
    input  logic                       req_write,
    input  logic [TAG_W-1:0]           req_tag,
    input  logic [1:0][ENT_W-1:0]      ent,
    output logic [1:0]                 hit,
    output logic [1:0][1:0]            rep_st,
    output logic [1:0][ENT_W-1:0]      new_ent,
    output logic                       supply,
    output logic                       supplier
);
    logic [1:0][TAG_W-1:0] tag_of;
    logic [1:0][1:0]       st_of;

    for (genvar p = 0; p < 2; p++) begin : g_proc
        assign tag_of[p] = ent[p][ENT_W-1:2];
        assign st_of[p]  = ent[p][1:0];
        assign hit[p]    = (st_of[p] != ST_INV) && (tag_of[p] == req_tag);
        assign rep_st[p] = hit[p] ? st_of[p] : ST_INV;

        always_comb begin
            if (req_pid == 1'(p)) begin
                if (req_write || !hit[1-p])
                    new_ent[p] = {req_tag, ST_EXM};
                else
                    new_ent[p] = {req_tag, ST_SHD};
            end else if (!hit[p]) begin
                new_ent[p] = ent[p];
            end else if (req_write) begin
                new_ent[p] = {tag_of[p], ST_INV};
            end else if (st_of[p] == ST_EXM) begin
                new_ent[p] = {tag_of[p], ST_OWN};
            end else begin
                new_ent[p] = ent[p];
            end
        end
    end

    assign supplier = ~req_pid;
    assign supply   = hit[supplier] && st_of[supplier][1];

    // R6: the two updated entries never both end up Exclusive/Modified on a shared tag
    always_comb begin
        if (new_ent[0][1:0] == ST_EXM && new_ent[1][1:0] == ST_EXM)
            p_single_owner_r6: assert (new_ent[0][ENT_W-1:2] != new_ent[1][ENT_W-1:2]);
    end
endmodule

// File: rtl/dtag_snoop_ctrl.sv
module dtag_snoop_ctrl
    import dtag_pkg::*;
#(
    parameter int TAG_W  = 13,
    parameter int IDX_W  = 4,
    parameter int SRAM_W = 18,
    parameter int PA_W   = TAG_W + IDX_W + dtag_pkg::OFF_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_pid,
    input  logic [PA_W-1:0]   req_addr,
    input  logic              req_write,
    output logic              rsp_valid,
    output logic [1:0]        rsp_hit,
    output logic [1:0]        rsp_state0,
    output logic [1:0]        rsp_state1,
    output logic              rsp_supply,
    output logic              rsp_supplier,
    output logic              sram_en,
    output logic              sram_we,
    output logic [IDX_W:0]    sram_addr,
    output logic [SRAM_W-1:0] sram_wdata,
    input  logic [SRAM_W-1:0] sram_rdata
);
    localparam int ENT_W = TAG_W + 2;
    localparam int PAD_W = SRAM_W - ENT_W;

    logic accept, rd_en, rd_sel, cap0, cap1, wr_en, wr_sel;

    logic             pid_q, write_q;
    logic [IDX_W-1:0] idx_q;
    logic [TAG_W-1:0] tag_q;
    logic [1:0][ENT_W-1:0] ent_q;
    logic [1:0][ENT_W-1:0] new_ent;
    logic [1:0][1:0]       rep_st;

    dtag_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_ready (req_ready),
        .accept    (accept),
        .rd_en     (rd_en),
        .rd_sel    (rd_sel),
        .cap0      (cap0),
        .cap1      (cap1),
        .wr_en     (wr_en),
        .wr_sel    (wr_sel),
        .rsp_valid (rsp_valid)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pid_q   <= 1'b0;
            write_q <= 1'b0;
            idx_q   <= '0;
            tag_q   <= '0;
            ent_q   <= '0;
        end else begin
            if (accept) begin
                pid_q   <= req_pid;
                write_q <= req_write;
                idx_q   <= req_addr[OFF_W +: IDX_W];
                tag_q   <= req_addr[PA_W-1 -: TAG_W];
            end
            if (cap0) ent_q[0] <= sram_rdata[ENT_W-1:0];
            if (cap1) ent_q[1] <= sram_rdata[ENT_W-1:0];
        end
    end

    dtag_merge #(.TAG_W(TAG_W), .ENT_W(ENT_W)) u_merge (
        .req_pid   (pid_q),
        .req_write (write_q),
        .req_tag   (tag_q),
        .ent       (ent_q),
        .hit       (rsp_hit),
        .rep_st    (rep_st),
        .new_ent   (new_ent),
        .supply    (rsp_supply),
        .supplier  (rsp_supplier)
    );

    assign rsp_state0 = rep_st[0];
    assign rsp_state1 = rep_st[1];

    assign sram_en    = rd_en || wr_en;
    assign sram_we    = wr_en;
    assign sram_addr  = {idx_q, (wr_en ? wr_sel : rd_sel)};
    assign sram_wdata = {{PAD_W{1'b0}}, new_ent[wr_sel]};

    p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (!sram_en && !rsp_valid));

    p_read_pair_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (sram_en && !sram_we && !sram_addr[0]) |=>
        (sram_en && !sram_we && sram_addr[0] && sram_addr[IDX_W:1] == $past(sram_addr[IDX_W:1])));

    p_rsp_after_reads_r3: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> $past(sram_en && !sram_we && sram_addr[0], 2));

    p_write_pad_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
        sram_we |-> (sram_wdata[SRAM_W-1:ENT_W] == '0));

    p_supply_in_rsp_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_supply) |-> rsp_hit[rsp_supplier]);
endmodule

// File: tb/dtag_snoop_ctrl_tb.sv
module dtag_snoop_ctrl_tb;
    localparam int CLK_PERIOD = 10;
    localparam int TAG_W = 13;
    localparam int IDX_W = 4;
    localparam int PA_W  = TAG_W + IDX_W + 6;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_valid = 1'b0;
    logic req_ready;
    logic req_pid = 1'b0;
    logic [PA_W-1:0] req_addr = '0;
    logic req_write = 1'b0;
    logic rsp_valid;
    logic [1:0] rsp_hit, rsp_state0, rsp_state1;
    logic rsp_supply, rsp_supplier;
    logic sram_en, sram_we;
    logic [IDX_W:0] sram_addr;
    logic [17:0] sram_wdata;
    logic [17:0] sram_rdata = '0;
    logic [17:0] mem [0:31];

    int checks = 0;
    int failures = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    always @(posedge clk) begin
        if (sram_en) begin
            if (sram_we) mem[sram_addr] <= sram_wdata;
            else         sram_rdata <= mem[sram_addr];
        end
    end

    dtag_snoop_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_pid(req_pid), .req_addr(req_addr), .req_write(req_write),
        .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_state0(rsp_state0),
        .rsp_state1(rsp_state1), .rsp_supply(rsp_supply), .rsp_supplier(rsp_supplier),
        .sram_en(sram_en), .sram_we(sram_we), .sram_addr(sram_addr),
        .sram_wdata(sram_wdata), .sram_rdata(sram_rdata)
    );

    task automatic chk(input bit ok, input string req, input int got, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s got=%0h exp=%0h", req, got, exp);
        end
    endtask

    task automatic run_case(input int sr, input int so, input bit mr, input bit mo,
                            input bit pid, input bit wr, input int n);
        logic [IDX_W-1:0] idx;
        logic [TAG_W-1:0] rtag, tag_r, tag_o;
        bit hr, ho;
        int exp_so, exp_sr, exp_sup, exp_st0, exp_st1;
        logic [17:0] exp_r, exp_o;
        idx   = IDX_W'(n);
        rtag  = TAG_W'(n * 37 + 5);
        tag_r = mr ? rtag : rtag ^ 13'h1555;
        tag_o = mo ? rtag : rtag ^ 13'h0aaa;
        @(negedge clk);
        mem[{idx, pid}]  = {3'b111, tag_r, 2'(sr)};
        mem[{idx, ~pid}] = {3'b101, tag_o, 2'(so)};
        hr = (sr != 0) && mr;
        ho = (so != 0) && mo;
        // expected values from R3..R7, R10
        exp_sup = (ho && so >= 2) ? 1 : 0;
        if (wr) begin
            exp_sr = 3;
            exp_so = ho ? 0 : so;
        end else begin
            exp_sr = ho ? 1 : 3;
            exp_so = (ho && so == 3) ? 2 : so;
        end
        exp_r = {3'b000, rtag, 2'(exp_sr)};
        exp_o = {3'b000, tag_o, 2'(exp_so)};
        exp_st0 = (pid == 0) ? (hr ? sr : 0) : (ho ? so : 0);
        exp_st1 = (pid == 1) ? (hr ? sr : 0) : (ho ? so : 0);
        chk(req_ready, "R1 idle ready", int'(req_ready), 1);
        req_valid = 1'b1;
        req_pid   = pid;
        req_write = wr;
        req_addr  = {rtag, idx, 6'(n)};
        for (int c = 1; c <= 6; c++) begin
            @(negedge clk);
            if (c == 5) req_valid = 1'b0;
            if (c <= 5) chk(!req_ready, "R8 busy", int'(req_ready), 0);
            else        chk(req_ready, "R8 ready again", int'(req_ready), 1);
            if (c == 1) chk(sram_en && !sram_we && sram_addr == {idx, 1'b0},
                            "R2 first read", int'(sram_addr), int'({idx, 1'b0}));
            if (c == 2) chk(sram_en && !sram_we && sram_addr == {idx, 1'b1},
                            "R2 second read", int'(sram_addr), int'({idx, 1'b1}));
            chk(rsp_valid == (c == 4), "R3 rsp timing", int'(rsp_valid), int'(c == 4));
            if (c == 4) begin
                chk(rsp_hit[pid] == hr, "R3 requester hit", int'(rsp_hit[pid]), int'(hr));
                chk(rsp_hit[~pid] == ho, "R7 other hit", int'(rsp_hit[~pid]), int'(ho));
                chk(rsp_state0 == 2'(exp_st0), "R3 state0", int'(rsp_state0), exp_st0);
                chk(rsp_state1 == 2'(exp_st1), "R3 state1", int'(rsp_state1), exp_st1);
                chk(rsp_supply == exp_sup[0], "R10 supply", int'(rsp_supply), exp_sup);
                if (exp_sup != 0)
                    chk(rsp_supplier == ~pid, "R10 supplier", int'(rsp_supplier), int'(~pid));
            end
        end
        chk(mem[{idx, pid}] == exp_r, wr ? "R6 requester entry" : "R5 requester entry",
            int'(mem[{idx, pid}]), int'(exp_r));
        chk(mem[{idx, ~pid}] == exp_o, wr ? "R6 other entry" : (ho ? "R4 other entry" : "R7 other kept"),
            int'(mem[{idx, ~pid}]), int'(exp_o));
        chk(mem[{idx, ~pid}][17:15] == 3'b000, "R9 pad zero",
            int'(mem[{idx, ~pid}][17:15]), 0);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin : main
        int n;
        for (int a = 0; a < 32; a++) mem[a] = '0;
        repeat (3) @(negedge clk);
        chk(req_ready, "R1 reset ready", int'(req_ready), 1);
        chk(!sram_en, "R1 reset sram idle", int'(sram_en), 0);
        chk(!rsp_valid, "R1 reset no rsp", int'(rsp_valid), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(req_ready && !sram_en && !rsp_valid, "R1 idle after reset",
            int'({req_ready, sram_en, rsp_valid}), 4);
        n = 0;
        for (int sr = 0; sr < 4; sr++)
            for (int so = 0; so < 4; so++)
                for (int mr = 0; mr < 2; mr++)
                    for (int mo = 0; mo < 2; mo++)
                        for (int p = 0; p < 2; p++)
                            for (int w = 0; w < 2; w++) begin
                                run_case(sr, so, mr[0], mo[0], p[0], w[0], n);
                                n++;
                            end
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule